// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a 14-bit virtual address into a physical address using three segment register sets. The top two address bits pick the segment: code, heap or stack. The low twelve bits give the offset into that segment. Each segment holds a base address, a size, a direction flag and three access-permission bits. A segment whose direction flag is clear grows downward. Its offset is measured back from the 4 KB maximum segment size, and it is subtracted from the base.

A requester presents a virtual address and an access type on a valid/ready port. One cycle after the request is accepted, the unit gives a registered response. The response carries either the physical address or a fault with its cause. The cause is an invalid segment, a permission fault or a bounds fault. Segment registers are loaded through a write port that takes effect only while the privileged-mode input is high. An attempt to write outside privileged mode changes nothing and raises a sticky violation flag.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset rspValid and privViol are 0 and reqReady is 1. Every segment register is 0: base 0, size 0 and no permissions, so every access faults with cause 2.
- R2: Address bits [13:12] select the segment: 00 code, 01 heap, 11 stack. Value 10 faults with cause 3 (invalid segment). Cause codes are 0 none, 1 bounds, 2 permission and 3 invalid segment.
- R3: In a segment with flags bit0 = 1 (grows upward), a legal access returns rspPaddr = base + offset (16-bit, wrapping).
- R4: In an upward segment, an offset greater than or equal to the size faults with cause 1.
- R5: In a segment with flags bit0 = 0 (grows downward), a legal access returns rspPaddr = base - (4096 - offset).
- R6: In a downward segment, the access is legal when 4096 - offset is less than or equal to the size. Otherwise it faults with cause 1.
- R7: reqType 0 is fetch and needs flags bit3. Type 1 is read and needs bit1. Type 2 is write and needs bit2. Type 3 is never permitted. A missing permission faults with cause 2.
- R8: Fault priority is invalid segment, then permission, then bounds. A fault response has rspFault = 1 and rspPaddr = 0. A good response has rspFault = 0 and cause 0.
- R9: A request is accepted when reqValid and reqReady are both high, and the response appears on the next cycle. reqReady = !rspValid || rspReady. While rspValid is high and rspReady is low, the response holds unchanged.
- R10: A register write occurs when regWrEn is high and privMode is high. regWrSeg uses the segment codes of R2. regWrField 0 loads the base from regWrData[15:0]. Field 1 loads the size from regWrData[12:0]. Field 2 loads the flags from regWrData[3:0]. Field 3 and segment code 10 are ignored.
- R11: A write attempted with privMode low changes no register and sets privViol. privViol stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privMode | input | 1 | Privileged mode; enables register writes |
| regWrEn | input | 1 | Register write strobe |
| regWrSeg | input | 2 | Segment code of the write target |
| regWrField | input | 2 | Field select: base, size or flags |
| regWrData | input | 16 | Write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | 14 | Virtual address |
| reqType | input | 2 | Access type: fetch, read, write |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Requester accepts the response |
| rspFault | output | 1 | Response is a fault |
| rspCause | output | 2 | Fault cause code |
| rspPaddr | output | 16 | Physical address, zero on fault |
| privViol | output | 1 | Sticky unprivileged-write flag |

## Verification
The bench sweeps the address space with every access type under two segment configurations. It aims at the exact size edges. For an upward segment the edge is offset size-1 against size. For a downward segment it is offset 4096-size against one below it. A design with an off-by-one in either compare would accept or reject exactly one address in the wrong way. The sweep also covers a downward segment of full 4 KB size. There a design that truncates the 4096-offset magnitude to twelve bits would produce the wrong address at offset 0. Further checks cover an access that breaks both permission and bounds, to catch wrong cause priority, and a stalled response, to catch a design that lets a held result change. Unprivileged writes and writes to the unused segment code are followed by translations that would show any register they corrupted.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int NSEG = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BOUNDS = 2'd1,
    CAUSE_PERM   = 2'd2,
    CAUSE_BADSEG = 2'd3
  } cause_e;

  typedef struct packed {
    logic       capture;
    logic       wrBase;
    logic       wrSize;
    logic       wrFlags;
    logic [1:0] wrIdx;
  } strobe_t;

  // Map a segment code onto a register-set index; code 10 has none.
  function automatic logic [1:0] segIndex(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       privMode,
  input  logic       regWrEn,
  input  logic [1:0] regWrSeg,
  input  logic [1:0] regWrField,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  output logic       privViol,
  output strobe_t    strb
);
  logic rspValidQ;
  logic privViolQ;
  logic wrAllowed;

  assign reqReady  = !rspValidQ || rspReady;
  assign wrAllowed = regWrEn && privMode && (regWrSeg != 2'b10);

  always_comb begin
    strb         = '0;
    strb.capture = reqValid && reqReady;
    strb.wrIdx   = segIndex(regWrSeg);
    strb.wrBase  = wrAllowed && (regWrField == 2'd0);
    strb.wrSize  = wrAllowed && (regWrField == 2'd1);
    strb.wrFlags = wrAllowed && (regWrField == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      privViolQ <= 1'b0;
    end else begin
      if (strb.capture)  rspValidQ <= 1'b1;
      else if (rspReady) rspValidQ <= 1'b0;
      if (regWrEn && !privMode) privViolQ <= 1'b1;
    end
  end

  assign rspValid = rspValidQ;
  assign privViol = privViolQ;
endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 14,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PA_W-1:0] regWrData,
  input  logic [VA_W-1:0] reqAddr,
  input  logic [1:0]      reqType,
  output logic            rspFault,
  output logic [1:0]      rspCause,
  output logic [PA_W-1:0] rspPaddr
);
  localparam int OFF_W = VA_W - 2;
  localparam logic [OFF_W:0] MAX_SEG = {1'b1, {OFF_W{1'b0}}};

  logic [PA_W-1:0] baseQ  [NSEG];
  logic [OFF_W:0]  sizeQ  [NSEG];
  logic [3:0]      flagsQ [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i]  <= '0;
        sizeQ[i]  <= '0;
        flagsQ[i] <= '0;
      end else if (strb.wrIdx == 2'(i)) begin
        if (strb.wrBase)  baseQ[i]  <= regWrData;
        if (strb.wrSize)  sizeQ[i]  <= regWrData[OFF_W:0];
        if (strb.wrFlags) flagsQ[i] <= regWrData[3:0];
      end
    end
  end

  logic [1:0]       segCode;
  logic [1:0]       idx;
  logic [OFF_W-1:0] offset;
  logic [OFF_W:0]   negMag;
  logic [PA_W-1:0]  selBase;
  logic [OFF_W:0]   selSize;
  logic [3:0]       selFlags;
  logic             permOk;
  logic             boundsOk;
  cause_e           cause;
  logic [PA_W-1:0]  paddr;

  assign segCode  = reqAddr[VA_W-1 -: 2];
  assign offset   = reqAddr[OFF_W-1:0];
  assign idx      = segIndex(segCode);
  assign selBase  = baseQ[idx];
  assign selSize  = sizeQ[idx];
  assign selFlags = flagsQ[idx];
  assign negMag   = MAX_SEG - {1'b0, offset};

  always_comb begin
    case (reqType)
      2'd0:    permOk = selFlags[3];
      2'd1:    permOk = selFlags[1];
      2'd2:    permOk = selFlags[2];
      default: permOk = 1'b0;
    endcase
    if (selFlags[0]) begin
      boundsOk = {1'b0, offset} < selSize;
      paddr    = selBase + PA_W'(offset);
    end else begin
      boundsOk = negMag <= selSize;
      paddr    = selBase - PA_W'(negMag);
    end
    if (segCode == 2'b10) cause = CAUSE_BADSEG;
    else if (!permOk)     cause = CAUSE_PERM;
    else if (!boundsOk)   cause = CAUSE_BOUNDS;
    else                  cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspCause <= '0;
      rspPaddr <= '0;
    end else if (strb.capture) begin
      rspFault <= (cause != CAUSE_NONE);
      rspCause <= cause;
      rspPaddr <= (cause == CAUSE_NONE) ? paddr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 14,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            privMode,
  input  logic            regWrEn,
  input  logic [1:0]      regWrSeg,
  input  logic [1:0]      regWrField,
  input  logic [PA_W-1:0] regWrData,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqAddr,
  input  logic [1:0]      reqType,
  output logic            rspValid,
  input  logic            rspReady,
  output logic            rspFault,
  output logic [1:0]      rspCause,
  output logic [PA_W-1:0] rspPaddr,
  output logic            privViol
);
  strobe_t strb;

  seg_xlate_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .privMode(privMode), .regWrEn(regWrEn),
    .regWrSeg(regWrSeg), .regWrField(regWrField), .reqValid(reqValid),
    .reqReady(reqReady), .rspValid(rspValid), .rspReady(rspReady),
    .privViol(privViol), .strb(strb)
  );

  seg_xlate_dp #(.VA_W(VA_W), .PA_W(PA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .reqAddr(reqAddr), .reqType(reqType), .rspFault(rspFault),
    .rspCause(rspCause), .rspPaddr(rspPaddr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int VA_W = 14,
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            privMode,
  input logic            regWrEn,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqAddr,
  input logic            rspValid,
  input logic            rspReady,
  input logic            rspFault,
  input logic [1:0]      rspCause,
  input logic [PA_W-1:0] rspPaddr,
  input logic            privViol
);
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPaddr) && $stable(rspCause) && $stable(rspFault)); // R9
  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid); // R9
  AST_BADSEG: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqAddr[VA_W-1 -: 2] == 2'b10 |=> rspFault && rspCause == 2'd3); // R2
  AST_FAULT_FORM: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPaddr == '0 && rspCause != 2'd0); // R8
  AST_GOOD_FORM: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspCause == 2'd0); // R8
  AST_PRIV_SET: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && !privMode |=> privViol); // R11
  AST_PRIV_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    privViol |=> privViol); // R11
endmodule

bind seg_xlate_top seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rstN(rstN), .privMode(privMode), .regWrEn(regWrEn),
  .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspReady(rspReady), .rspFault(rspFault),
  .rspCause(rspCause), .rspPaddr(rspPaddr), .privViol(privViol)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSeg = '0;
  logic [1:0]  regWrField = '0;
  logic [15:0] regWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [13:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic [15:0] rspPaddr;
  logic        privViol;

  int checks = 0;
  int fails = 0;

  logic [15:0] mBase  [3];
  logic [12:0] mSize  [3];
  logic [3:0]  mFlags [3];

  always #4 clk = ~clk;

  seg_xlate_top dut_i (
    .clk(clk), .rstN(rstN), .privMode(privMode), .regWrEn(regWrEn),
    .regWrSeg(regWrSeg), .regWrField(regWrField), .regWrData(regWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqType(reqType), .rspValid(rspValid), .rspReady(rspReady),
    .rspFault(rspFault), .rspCause(rspCause), .rspPaddr(rspPaddr),
    .privViol(privViol)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [13:0] a, input logic [1:0] t,
                       output logic [1:0] c, output logic [15:0] pa,
                       output string tag);
    int s;
    int off;
    int mag;
    bit pOk;
    bit bOk;
    off = int'(a[11:0]);
    case (a[13:12])
      2'b00: s = 0;
      2'b01: s = 1;
      2'b11: s = 2;
      default: s = -1;
    endcase
    pa = 16'd0;
    if (s < 0) begin
      c = 2'd3; tag = "R2"; return;
    end
    pOk = (t == 2'd0) ? mFlags[s][3] : (t == 2'd1) ? mFlags[s][1] :
          (t == 2'd2) ? mFlags[s][2] : 1'b0;
    mag = 4096 - off;
    if (mFlags[s][0]) bOk = off < int'(mSize[s]);
    else              bOk = mag <= int'(mSize[s]);
    if (!pOk) begin
      c = 2'd2; tag = "R7";
    end else if (!bOk) begin
      c = 2'd1; tag = mFlags[s][0] ? "R4" : "R6";
    end else begin
      c = 2'd0;
      tag = mFlags[s][0] ? "R3" : "R5";
      pa = mFlags[s][0] ? 16'(int'(mBase[s]) + off) : 16'(int'(mBase[s]) - mag);
    end
  endtask

  task automatic doReq(input logic [13:0] a, input logic [1:0] t, input string force_tag);
    logic [1:0]  ec;
    logic [15:0] ep;
    string       tag;
    model(a, t, ec, ep, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    reqAddr = a; reqType = t; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1 && rspFault == (ec != 2'd0) && rspCause == ec && rspPaddr == ep,
          tag, $sformatf("addr=%0d type=%0d cause/pa", a, t),
          int'(rspCause) * 65536 + int'(rspPaddr), int'(ec) * 65536 + int'(ep));
  endtask

  task automatic wrReg(input logic [1:0] seg, input logic [1:0] fld,
                       input logic [15:0] d, input logic priv);
    int s;
    @(negedge clk);
    regWrSeg = seg; regWrField = fld; regWrData = d; privMode = priv; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; privMode = 1'b0;
    s = (seg == 2'b00) ? 0 : (seg == 2'b01) ? 1 : (seg == 2'b11) ? 2 : -1;
    if (priv && s >= 0) begin
      if (fld == 2'd0) mBase[s] = d;
      if (fld == 2'd1) mSize[s] = d[12:0];
      if (fld == 2'd2) mFlags[s] = d[3:0];
    end
  endtask

  task automatic setSeg(input logic [1:0] seg, input logic [15:0] b,
                        input logic [15:0] sz, input logic [15:0] fl);
    wrReg(seg, 2'd0, b, 1'b1);
    wrReg(seg, 2'd1, sz, 1'b1);
    wrReg(seg, 2'd2, fl, 1'b1);
  endtask

  task automatic sweep();
    for (int a = 0; a < 16384; a += 29)
      for (int t = 0; t < 4; t++)
        doReq(14'(a), 2'(t), "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] heldPa;
    logic [1:0]  heldCause;
    for (int i = 0; i < 3; i++) begin
      mBase[i] = '0; mSize[i] = '0; mFlags[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rspValid == 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);
    check(privViol == 1'b0, "R1", "privViol after reset", int'(privViol), 0);
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    doReq(14'd0, 2'd1, "R1");
    doReq(14'h3F00, 2'd2, "R1");

    // Configuration A: code 32K/2K up RX, heap 34K/2K up RW, stack 28K/2K down RW (R10)
    setSeg(2'b00, 16'd32768, 16'd2048, 16'hB);
    setSeg(2'b01, 16'd34816, 16'd2048, 16'h7);
    setSeg(2'b11, 16'd28672, 16'd2048, 16'h6);
    doReq(14'd100, 2'd0, "R10");
    doReq(14'd4200, 2'd1, "R3");
    doReq(14'd15360, 2'd1, "R5");
    doReq(14'h1000 + 14'd2047, 2'd2, "R4");
    doReq(14'h1000 + 14'd2048, 2'd2, "R4");
    doReq(14'h3000 + 14'd2048, 2'd1, "R6");
    doReq(14'h3000 + 14'd2047, 2'd1, "R6");
    doReq(14'h3000 + 14'd4095, 2'd2, "R5");
    doReq(14'h2000 + 14'd5, 2'd1, "R2");
    doReq(14'd3000, 2'd2, "R8");
    doReq(14'd100, 2'd3, "R7");
    doReq(14'd100, 2'd2, "R7");
    sweep();

    // R11 unprivileged write ignored, flag sticky
    wrReg(2'b01, 2'd0, 16'h1234, 1'b0);
    check(privViol == 1'b1, "R11", "privViol after unprivileged write", int'(privViol), 1);
    doReq(14'd4200, 2'd1, "R11");
    wrReg(2'b01, 2'd2, 16'h0, 1'b0);
    doReq(14'd4200, 2'd2, "R11");
    repeat (5) @(negedge clk);
    check(privViol == 1'b1, "R11", "privViol sticky", int'(privViol), 1);

    // R10 writes to segment code 10 and field 3 ignored
    wrReg(2'b10, 2'd0, 16'h0BAD, 1'b1);
    wrReg(2'b10, 2'd2, 16'h0, 1'b1);
    wrReg(2'b00, 2'd3, 16'h0, 1'b1);
    doReq(14'd100, 2'd0, "R10");
    doReq(14'd4200, 2'd1, "R10");
    doReq(14'd15360, 2'd2, "R10");

    // R9 stalled response held
    @(negedge clk);
    rspReady = 1'b0;
    reqAddr = 14'd4200; reqType = 2'd1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    heldPa = rspPaddr; heldCause = rspCause;
    check(rspValid == 1'b1 && rspPaddr == 16'd34920, "R9", "response after accept",
          int'(rspPaddr), 34920);
    check(reqReady == 1'b0, "R9", "reqReady during stall", int'(reqReady), 0);
    reqAddr = 14'h2000; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    check(rspValid == 1'b1 && rspPaddr == heldPa && rspCause == heldCause, "R9",
          "response held under stall", int'(rspPaddr), int'(heldPa));
    reqValid = 1'b0;
    rspReady = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R9", "rspValid drops after release", int'(rspValid), 0);

    // Configuration B: full-size segments, empty heap
    setSeg(2'b00, 16'd0, 16'd4096, 16'hF);
    setSeg(2'b01, 16'hF000, 16'd0, 16'h7);
    setSeg(2'b11, 16'h1000, 16'd4096, 16'hE);
    doReq(14'h3000, 2'd0, "R6");
    doReq(14'h0FFF, 2'd2, "R4");
    doReq(14'h1000, 2'd1, "R4");
    sweep();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule